// File: doc/BRIEF.md
# Multi-Ring Thread Context Matcher

This block decides which hardware thread, and which of its rings, should take a notification. A request names a target by a format bit, a block number and an index (the pair forms the target CAM value), an ignore flag and a logical server number. Each thread presents three context words: the pool ring, the OS ring and the user ring. A pool or OS word is a valid bit over a CAM field. A user word is a valid bit over a logical server field. All threads are compared in parallel.

The result is registered and appears one cycle after the request strobe. It is one of five outcomes: a single hit with its thread index and ring code, a duplicate (two or more threads match), not dispatched (no thread matches), unsupported (a logical server request), or rejected (the target entry is not marked valid). The logic that picks a winner among logical servers, backlog handling and escalation all sit outside this block.

Top module: `cam_thread_matcher`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. In every other cycle, and after reset, all response outputs are zero.
- R2: When `req_entry_ok` is low the response has only `rsp_reject` set. This takes precedence over every other outcome, including R3.
- R3: A request with format 0 and `req_ign` set is a logical server request. The response has only `rsp_unsup` set.
- R4: With format 0 and the ignore flag clear, a thread's pool ring matches when the pool valid bit (the MSB) is set and its CAM field (the low bits, equal to `{req_blk, req_idx}`) equals the target. The ring codes are 0 for user, 1 for OS and 2 for pool. Code 3 is never reported.
- R5: With format 0 the pool ring is checked before the OS ring in each thread. The OS ring (code 1) matches under the same valid-and-CAM rule only when the pool ring does not.
- R6: With format 1 only the user ring (code 0) can match. It needs both of these: the OS ring is valid with a CAM equal to the target, and the user ring is valid with a logical server field (the low bits) equal to `req_lsrv`. The pool ring and `req_ign` play no part.
- R7: When exactly one thread matches, `rsp_hit` is set and `rsp_thread`/`rsp_ring` give that thread and its ring.
- R8: When two or more threads match, `rsp_dup` is set and `rsp_hit` is clear. `rsp_thread`/`rsp_ring` give the lowest-numbered matching thread.
- R9: When no thread matches, `rsp_nodisp` is set. `rsp_thread` and `rsp_ring` are zero whenever neither hit nor duplicate is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 1 | Format: 0 specific target, 1 user level |
| req_blk | input | BLK_W | Target block number |
| req_idx | input | IDX_W | Target index |
| req_ign | input | 1 | Ignore flag (logical server request when format 0) |
| req_lsrv | input | LS_W | Requested logical server number |
| req_entry_ok | input | 1 | Target entry present and valid |
| pool_ctx | input | N_THR*(BLK_W+IDX_W+1) | Pool words, thread 0 in the low slice |
| os_ctx | input | N_THR*(BLK_W+IDX_W+1) | OS words, thread 0 in the low slice |
| usr_ctx | input | N_THR*(LS_W+1) | User words, thread 0 in the low slice |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Single match found |
| rsp_dup | output | 1 | More than one thread matched |
| rsp_nodisp | output | 1 | No thread matched |
| rsp_reject | output | 1 | Target entry not valid |
| rsp_unsup | output | 1 | Logical server request |
| rsp_thread | output | TID_W | Matching thread index |
| rsp_ring | output | 2 | Matching ring code |

## Verification
One thread's pool and OS rings both hold the target. A design with the wrong ring order would report OS instead of pool. One thread has an invalid pool word whose CAM still equals the target. A design that skips the valid bit would report pool there. Two threads share an OS CAM, which catches a design that silently keeps the first or last match instead of flagging a duplicate. User-level requests are aimed at a CAM that exists only in a pool ring, and at a logical server mismatch. A design that checked the wrong ring or dropped a user-level condition would then report a false hit. Requests that are both unsupported and rejected show whether precedence was inverted.

// File: rtl/cam_match_pkg.sv
// Package: ring codes shared by the matcher and its checker.
package cam_match_pkg;
    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;
endpackage

// File: rtl/ctx_ring_match.sv
// Compares one thread's ring words with the target.
// Assumes each word is {valid, field}, with the field in the low bits.
module ctx_ring_match
    import cam_match_pkg::*;
#(
    parameter int CAM_W = 20,
    parameter int LS_W  = 16
) (
    input  logic             fmt,
    input  logic [CAM_W-1:0] cam,
    input  logic [LS_W-1:0]  lsrv,
    input  logic [CAM_W:0]   pool_w,
    input  logic [CAM_W:0]   os_w,
    input  logic [LS_W:0]    usr_w,
    output logic             hit,
    output ring_e            ring
);
    logic pool_ok, os_ok, usr_ok;

    // Per-ring qualification: valid bit and field equality.
    always_comb begin
        pool_ok = pool_w[CAM_W] && (pool_w[CAM_W-1:0] == cam);
        os_ok   = os_w[CAM_W]   && (os_w[CAM_W-1:0]   == cam);
        usr_ok  = usr_w[LS_W]   && (usr_w[LS_W-1:0]   == lsrv);
    end

    // Ring selection: pool before OS for format 0, user for format 1.
    always_comb begin
        hit  = 1'b0;
        ring = RING_USER;
        if (!fmt) begin
            if (pool_ok) begin
                hit  = 1'b1;
                ring = RING_POOL;
            end else if (os_ok) begin
                hit  = 1'b1;
                ring = RING_OS;
            end
        end else if (os_ok && usr_ok) begin
            hit  = 1'b1;
            ring = RING_USER;
        end
    end
endmodule

// File: rtl/match_resolve.sv
// Reduces per-thread hits to: any match, multiple matches,
// and the lowest matching thread with its ring.
module match_resolve
    import cam_match_pkg::*;
#(
    parameter int N_THR = 4,
    parameter int TID_W = 2
) (
    input  logic [N_THR-1:0] hits,
    input  ring_e            rings [N_THR],
    output logic             any,
    output logic             multi,
    output logic [TID_W-1:0] first_tid,
    output ring_e            first_ring
);
    // Downward scan so that the lowest index is assigned last.
    always_comb begin
        any        = 1'b0;
        multi      = 1'b0;
        first_tid  = '0;
        first_ring = RING_USER;
        for (int i = N_THR - 1; i >= 0; i--) begin
            if (hits[i]) begin
                if (any) multi = 1'b1;
                any        = 1'b1;
                first_tid  = TID_W'(i);
                first_ring = rings[i];
            end
        end
    end
endmodule

// File: rtl/cam_thread_matcher.sv
// Top: matches a notification target against every thread's rings.
// Outputs are registered, so the result follows the request by one cycle.
// Assumes the context inputs are stable during the request cycle.
module cam_thread_matcher
    import cam_match_pkg::*;
#(
    parameter int N_THR = 4,
    parameter int BLK_W = 4,
    parameter int IDX_W = 16,
    parameter int LS_W  = 16,
    localparam int CAM_W = BLK_W + IDX_W,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_fmt,
    input  logic [BLK_W-1:0]         req_blk,
    input  logic [IDX_W-1:0]         req_idx,
    input  logic                     req_ign,
    input  logic [LS_W-1:0]          req_lsrv,
    input  logic                     req_entry_ok,
    input  logic [N_THR*(CAM_W+1)-1:0] pool_ctx,
    input  logic [N_THR*(CAM_W+1)-1:0] os_ctx,
    input  logic [N_THR*(LS_W+1)-1:0]  usr_ctx,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_dup,
    output logic                     rsp_nodisp,
    output logic                     rsp_reject,
    output logic                     rsp_unsup,
    output logic [TID_W-1:0]         rsp_thread,
    output logic [1:0]               rsp_ring
);
    logic [CAM_W-1:0] tgt_cam;
    logic [N_THR-1:0] thr_hit;
    ring_e            thr_ring [N_THR];
    logic             any_hit, multi_hit;
    logic [TID_W-1:0] win_tid;
    ring_e            win_ring;
    logic             n_rej, n_uns, n_hit, n_dup, n_nod;

    assign tgt_cam = {req_blk, req_idx};

    // One comparator per thread.
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        ctx_ring_match #(.CAM_W(CAM_W), .LS_W(LS_W)) u_match (
            .fmt    (req_fmt),
            .cam    (tgt_cam),
            .lsrv   (req_lsrv),
            .pool_w (pool_ctx[t*(CAM_W+1) +: CAM_W+1]),
            .os_w   (os_ctx[t*(CAM_W+1) +: CAM_W+1]),
            .usr_w  (usr_ctx[t*(LS_W+1) +: LS_W+1]),
            .hit    (thr_hit[t]),
            .ring   (thr_ring[t])
        );
    end

    match_resolve #(.N_THR(N_THR), .TID_W(TID_W)) u_resolve (
        .hits       (thr_hit),
        .rings      (thr_ring),
        .any        (any_hit),
        .multi      (multi_hit),
        .first_tid  (win_tid),
        .first_ring (win_ring)
    );

    // Outcome classification: reject, then unsupported, then match count.
    always_comb begin
        n_rej = !req_entry_ok;
        n_uns = req_entry_ok && !req_fmt && req_ign;
        n_hit = req_entry_ok && !n_uns && any_hit && !multi_hit;
        n_dup = req_entry_ok && !n_uns && multi_hit;
        n_nod = req_entry_ok && !n_uns && !any_hit;
    end

    // Response register: zero when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_dup    <= 1'b0;
            rsp_nodisp <= 1'b0;
            rsp_reject <= 1'b0;
            rsp_unsup  <= 1'b0;
            rsp_thread <= '0;
            rsp_ring   <= 2'd0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= n_hit;
            rsp_dup    <= n_dup;
            rsp_nodisp <= n_nod;
            rsp_reject <= n_rej;
            rsp_unsup  <= n_uns;
            rsp_thread <= (n_hit || n_dup) ? win_tid : '0;
            rsp_ring   <= (n_hit || n_dup) ? win_ring : 2'd0;
        end
    end
endmodule

// File: rtl/cam_match_checker.sv
// Checker: temporal properties of the matcher response, bound to the top.
module cam_match_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_fmt,
    input logic       req_ign,
    input logic       req_entry_ok,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_dup,
    input logic       rsp_nodisp,
    input logic       rsp_reject,
    input logic       rsp_unsup,
    input logic [1:0] rsp_ring
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_dup && !rsp_nodisp
                       && !rsp_reject && !rsp_unsup);
    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_entry_ok |=> rsp_reject && !rsp_unsup && !rsp_hit);
    assert_unsup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_entry_ok && !req_fmt && req_ign |=> rsp_unsup && !rsp_hit);
    assert_no_phys_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_ring != 2'd3);
    assert_user_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_entry_ok && req_fmt |=> !(rsp_hit && rsp_ring != 2'd0));
    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_dup, rsp_nodisp, rsp_reject, rsp_unsup}) == 1);
endmodule

bind cam_thread_matcher cam_match_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_fmt      (req_fmt),
    .req_ign      (req_ign),
    .req_entry_ok (req_entry_ok),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_dup      (rsp_dup),
    .rsp_nodisp   (rsp_nodisp),
    .rsp_reject   (rsp_reject),
    .rsp_unsup    (rsp_unsup),
    .rsp_ring     (rsp_ring)
);

// File: tb/tb_cam_thread_matcher.sv
// Bench: a vector table against a fixed thread setup, then directed cases.
module tb_cam_thread_matcher;
    localparam int N_THR = 4, BLK_W = 4, IDX_W = 16, LS_W = 16;
    localparam int CAM_W = BLK_W + IDX_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_fmt = 0, req_ign = 0, req_entry_ok = 0;
    logic [BLK_W-1:0] req_blk = '0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [LS_W-1:0]  req_lsrv = '0;
    logic [N_THR*(CAM_W+1)-1:0] pool_ctx = '0, os_ctx = '0;
    logic [N_THR*(LS_W+1)-1:0]  usr_ctx = '0;
    logic rsp_valid, rsp_hit, rsp_dup, rsp_nodisp, rsp_reject, rsp_unsup;
    logic [1:0] rsp_thread, rsp_ring;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cam_thread_matcher #(.N_THR(N_THR), .BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
        .req_blk(req_blk), .req_idx(req_idx), .req_ign(req_ign), .req_lsrv(req_lsrv),
        .req_entry_ok(req_entry_ok), .pool_ctx(pool_ctx), .os_ctx(os_ctx),
        .usr_ctx(usr_ctx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_dup(rsp_dup), .rsp_nodisp(rsp_nodisp), .rsp_reject(rsp_reject),
        .rsp_unsup(rsp_unsup), .rsp_thread(rsp_thread), .rsp_ring(rsp_ring));

    // Vector: fmt, ign, ok, blk[4], idx[16], lsrv[16], {hit,dup,nod,rej,uns}, thread[2], ring[2]
    localparam int NV = 14;
    localparam logic [47:0] VEC [NV] = '{
        {3'b001, 4'h1, 16'h0010, 16'h0000, 5'b10000, 2'd0, 2'd2},
        {3'b001, 4'h2, 16'h0030, 16'h0000, 5'b10000, 2'd1, 2'd1},
        {3'b001, 4'h3, 16'h0040, 16'h0000, 5'b10000, 2'd2, 2'd2},
        {3'b001, 4'h1, 16'h0020, 16'h0000, 5'b01000, 2'd0, 2'd1},
        {3'b001, 4'h9, 16'h0000, 16'h0000, 5'b00100, 2'd0, 2'd0},
        {3'b011, 4'h1, 16'h0010, 16'h0000, 5'b00001, 2'd0, 2'd0},
        {3'b000, 4'h1, 16'h0010, 16'h0000, 5'b00010, 2'd0, 2'd0},
        {3'b101, 4'h2, 16'h0030, 16'h0066, 5'b00100, 2'd0, 2'd0},
        {3'b101, 4'h3, 16'h0040, 16'h0077, 5'b10000, 2'd2, 2'd0},
        {3'b101, 4'h3, 16'h0040, 16'h0078, 5'b00100, 2'd0, 2'd0},
        {3'b101, 4'h1, 16'h0020, 16'h0055, 5'b01000, 2'd0, 2'd0},
        {3'b101, 4'h1, 16'h0010, 16'h0055, 5'b00100, 2'd0, 2'd0},
        {3'b111, 4'h3, 16'h0040, 16'h0077, 5'b10000, 2'd2, 2'd0},
        {3'b010, 4'h1, 16'h0010, 16'h0000, 5'b00010, 2'd0, 2'd0}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R4"; 1: return "R5"; 2: return "R5"; 3: return "R8";
            4: return "R9"; 5: return "R3"; 6: return "R2"; 7: return "R6";
            8: return "R7"; 9: return "R6"; 10: return "R8"; 11: return "R6";
            12: return "R6"; default: return "R2";
        endcase
    endfunction

    task automatic set_thr(int t, logic pv, logic [CAM_W-1:0] pc,
                           logic ov, logic [CAM_W-1:0] oc, logic uv, logic [LS_W-1:0] ul);
        pool_ctx[t*(CAM_W+1) +: CAM_W+1] = {pv, pc};
        os_ctx[t*(CAM_W+1) +: CAM_W+1]   = {ov, oc};
        usr_ctx[t*(LS_W+1) +: LS_W+1]    = {uv, ul};
    endtask

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] rsp_now();
        return {rsp_valid, rsp_hit, rsp_dup, rsp_nodisp, rsp_reject, rsp_unsup,
                rsp_thread, rsp_ring};
    endfunction

    // Drive one request at a falling edge and check at the next falling edge.
    task automatic run(string tag, logic [47:0] v);
        @(negedge clk);
        {req_fmt, req_ign, req_entry_ok, req_blk, req_idx, req_lsrv} = v[47:9];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, rsp_now(), {1'b1, v[8:0]});
    endtask

    initial begin
        // Fixed setup: T0 pool A/OS B/user 55, T1 pool off(C)/OS C/user off 66,
        // T2 pool D/OS D/user 77, T3 pool off/OS B/user 55.
        set_thr(0, 1, 20'h10010, 1, 20'h10020, 1, 16'h0055);
        set_thr(1, 0, 20'h20030, 1, 20'h20030, 0, 16'h0066);
        set_thr(2, 1, 20'h30040, 1, 20'h30040, 1, 16'h0077);
        set_thr(3, 0, 20'h00000, 1, 20'h10020, 1, 16'h0055);
        repeat (3) @(negedge clk);
        check("R1 reset", rsp_now(), 10'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run(vtag(i), VEC[i]);
        // R1: idle cycle after a request returns to zero
        @(negedge clk);
        check("R1 idle", rsp_now(), 10'd0);
        // R1: back-to-back requests each produce a response
        @(negedge clk);
        {req_fmt, req_ign, req_entry_ok, req_blk, req_idx, req_lsrv} = VEC[0][47:9];
        req_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", rsp_now(), {1'b1, VEC[0][8:0]});
        {req_fmt, req_ign, req_entry_ok, req_blk, req_idx, req_lsrv} = VEC[4][47:9];
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 b2b second", rsp_now(), {1'b1, VEC[4][8:0]});
        // R7: T3 OS moved away, user request B now hits T0 alone
        set_thr(3, 1, 20'h5_0050, 1, 20'h6_0060, 1, 16'h0055);
        run("R7 single user", {3'b101, 4'h1, 16'h0020, 16'h0055, 5'b10000, 2'd0, 2'd0});
        // R7: highest thread index reported, pool ring
        run("R7 thread3 pool", {3'b001, 4'h5, 16'h0050, 16'h0000, 5'b10000, 2'd3, 2'd2});
        // R8: three threads share pool CAM, lowest reported
        set_thr(1, 1, 20'h5_0050, 0, 20'h0, 0, 16'h0);
        set_thr(2, 1, 20'h5_0050, 1, 20'h3_0040, 1, 16'h0077);
        run("R8 triple dup", {3'b001, 4'h5, 16'h0050, 16'h0000, 5'b01000, 2'd1, 2'd2});
        // R2: reject with format 1 as well
        run("R2 reject fmt1", {3'b100, 4'h5, 16'h0050, 16'h0000, 5'b00010, 2'd0, 2'd0});
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule